// File: doc/BRIEF.md
# Interrupt mask set/clear controller

This block gathers up to eight level-sensitive interrupt sources and drives one interrupt request to a processor. An enable mask decides which sources may raise that request. Software never writes the mask as a whole word. It changes the mask through two write-only ports: one sets bits and the other clears them. Each write affects only the mask bits where the written byte holds a 1.

The bus has a single select line, so it has two locations. Location 0 reads back the enable mask, and a write there sets bits. Location 1 reads back the pending status, and a write there clears bits. Pending status is the live source levels ANDed with the mask. Sources are not latched. A source is pending only while its input is held high.

To mask source n, software writes the one-hot byte (1 << n) to location 1. To unmask it, software writes the same byte to location 0. Writing 0xFF to location 1 disables every source.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After synchronous reset the mask is 0x00, `rd_data` is 0x00 and `irq_out` is 0.
- R2: A write with `bus_sel`=0 sets every mask bit whose `wr_data` bit is 1 and leaves the other mask bits unchanged.
- R3: A write with `bus_sel`=1 clears every mask bit whose `wr_data` bit is 1 and leaves the other mask bits unchanged. Writing 0xFF disables every source, and a one-hot byte masks only that one source.
- R4: Writing 0x00 to either location leaves the mask unchanged. The sequence clear 0xFF, set 0x55, set 0x00 reads back 0x55 from location 0.
- R5: A read with `bus_sel`=0 returns the mask on `rd_data` from the clock edge that samples `rd_en`.
- R6: A read with `bus_sel`=1 returns `irq_in` AND mask on `rd_data`, with both values taken at the edge that samples `rd_en`.
- R7: `irq_out` is the OR of (`irq_in` AND mask), registered by one clock. It stays high for as long as an enabled source is held high.
- R8: When a read and a write occur in the same cycle, `rd_data` returns the value from before the write, and the write still takes effect.
- R9: `rd_data` holds its last value while `rd_en` is low.
- R10: Sources are not latched. When a source input falls, the status read and `irq_out` follow it with no sticky state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Location select: 0 selects the mask/set location, 1 selects the status/clear location |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Level source inputs |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Every result is due one clock edge after its stimulus. A write changes the mask at the edge that samples `wr_en`. A read result appears on `rd_data` at the edge that samples `rd_en`. `irq_out` reflects `irq_in` and the mask as they stood just before the previous edge, so a change to the mask reaches `irq_out` two edges after the write is sampled. The bench drives and samples on falling edges, and its reference model advances on rising edges, so each comparison falls half a cycle after the edge that produced the result. Directed checks wait two falling edges after any change before they look at `irq_out`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic SEL_MASK_SET   = 1'b0;
  localparam logic SEL_STAT_CLEAR = 1'b1;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             bus_sel,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] mask_q
);
  import irqc_pkg::*;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) mask_q[i] <= 1'b0;
      else if (wr_en && wr_data[i]) mask_q[i] <= (bus_sel == SEL_MASK_SET);
    end
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> mask_q == '0);
  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_sel == SEL_MASK_SET) |=>
      mask_q == ($past(mask_q) | $past(wr_data)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_sel == SEL_STAT_CLEAR) |=>
      mask_q == ($past(mask_q) & ~$past(wr_data)));
  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             bus_sel,
  input  logic [N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0] irq_in,
  output logic [N_SRC-1:0] rd_data
);
  import irqc_pkg::*;

  logic [N_SRC-1:0] rd_next;

  always_comb begin
    if (bus_sel == SEL_STAT_CLEAR) rd_next = irq_in & mask_q;
    else                           rd_next = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_sel == SEL_MASK_SET) |=> rd_data == $past(mask_q));
  assert_stat_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_sel == SEL_STAT_CLEAR) |=>
      (rd_data & ~$past(mask_q)) == '0);
endmodule

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0] irq_in,
  output logic             irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(irq_in & mask_q);
  end

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq_out);
  assert_level_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in) == '0) |-> !irq_out);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_data,
  input  logic             rd_en,
  output logic [N_SRC-1:0] rd_data,
  input  logic [N_SRC-1:0] irq_in,
  output logic             irq_out
);
  logic [N_SRC-1:0] mask_q;

  irqc_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bus_sel(bus_sel),
    .wr_data(wr_data), .mask_q(mask_q));

  irqc_readback #(.N_SRC(N_SRC)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .bus_sel(bus_sel),
    .mask_q(mask_q), .irq_in(irq_in), .rd_data(rd_data));

  irqc_request #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst(rst), .mask_q(mask_q), .irq_in(irq_in),
    .irq_out(irq_out));
endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] irq_in = 8'h00;
  logic [7:0] rd_data;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] m_mask = 8'h00;
  logic [7:0] m_rd = 8'h00;
  logic m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_mask_ctrl dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_in(irq_in), .irq_out(irq_out));

  // Reference model, advanced on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_mask <= 8'h00; m_rd <= 8'h00; m_irq <= 1'b0;
    end else begin
      if (rd_en) m_rd <= bus_sel ? (irq_in & m_mask) : m_mask;
      m_irq <= (irq_in & m_mask) != 8'h00;
      if (wr_en) m_mask <= bus_sel ? (m_mask & ~wr_data) : (m_mask | wr_data);
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R5 R6 model rd_data", rd_data, m_rd);
      check("R7 model irq_out", {7'd0, irq_out}, {7'd0, m_irq});
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk); bus_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic bus_rw(input logic sel, input logic [7:0] wd, output logic [7:0] d);
    @(negedge clk); bus_sel = sel; wr_data = wd; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00; d = rd_data;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 8'h00);
    check("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
    bus_read(1'b0, v); check("R1 mask after reset", v, 8'h00);

    bus_write(1'b1, 8'hFF); bus_write(1'b0, 8'h55); bus_write(1'b0, 8'h00);
    bus_read(1'b0, v); check("R4 set/zero sequence", v, 8'h55);
    bus_write(1'b1, 8'h00);
    bus_read(1'b0, v); check("R4 zero clear", v, 8'h55);

    bus_write(1'b0, 8'h0A);
    bus_read(1'b0, v); check("R2 set bits", v, 8'h5F);
    bus_write(1'b1, 8'h41);
    bus_read(1'b0, v); check("R3 clear bits", v, 8'h1E);

    irq_in = 8'h01; settle();
    check("R7 disabled source no irq", {7'd0, irq_out}, 8'h00);
    bus_read(1'b1, v); check("R6 status masked", v, 8'h00);
    irq_in = 8'h03; settle();
    check("R7 enabled source irq", {7'd0, irq_out}, 8'h01);
    bus_read(1'b1, v); check("R6 status enabled", v, 8'h02);
    repeat (5) @(negedge clk);
    check("R7 level held", {7'd0, irq_out}, 8'h01);
    irq_in = 8'h00; settle();
    check("R10 irq drops", {7'd0, irq_out}, 8'h00);
    bus_read(1'b1, v); check("R10 status clears", v, 8'h00);

    irq_in = 8'h02; settle();
    bus_write(1'b1, 8'h02); settle();
    check("R3 one-hot mask", {7'd0, irq_out}, 8'h00);
    bus_read(1'b0, v); check("R3 one-hot mask value", v, 8'h1C);
    bus_write(1'b0, 8'h02); settle();
    check("R2 one-hot unmask", {7'd0, irq_out}, 8'h01);
    bus_write(1'b1, 8'hFF); settle();
    check("R3 clear all", {7'd0, irq_out}, 8'h00);
    bus_read(1'b0, v); check("R3 clear all value", v, 8'h00);
    bus_write(1'b0, 8'h1C);
    irq_in = 8'h00;

    bus_rw(1'b0, 8'h01, v); check("R8 set read old", v, 8'h1C);
    bus_read(1'b0, v); check("R8 set took effect", v, 8'h1D);
    irq_in = 8'h04;
    bus_rw(1'b1, 8'h04, v); check("R8 clear read old status", v, 8'h04);
    bus_read(1'b1, v); check("R8 clear took effect", v, 8'h00);

    bus_read(1'b0, v);
    irq_in = 8'hFF; repeat (4) @(negedge clk);
    check("R9 rd_data held", rd_data, 8'h19);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule